// File: doc/BRIEF.md
# Serial port interrupt status logic

This block produces the interrupt conditions of a synchronous serial port controller. It observes level and strobe signals from the receive and transmit FIFOs, a strobe that marks the end of each received frame, and the serial bit-rate settings. From these it keeps four raw conditions:
- receive overrun
- receive idle timeout
- receive FIFO at least half full
- transmit FIFO at least half empty

A small register port lets software program an enable mask, read the raw and masked conditions, and clear the two sticky conditions by writing ones.

The overrun and timeout conditions are sticky flags held in the block. The two FIFO-level conditions are passed straight through from their inputs and go away only when the FIFO is accessed; masking them is the only way to silence them. The timeout length tracks the bit rate: it is 32 serial bit periods. One bit period is `prescale * (rate + 1)` clocks.

Top module: `serial_irq_status`

## Requirements
- R1: After reset the enable mask, both sticky flags, the masked status and `irq_out` are all 0.
- R2: A write to address 0 loads the enable mask from `reg_wdata[3:0]`. Reading address 0 returns the mask in bits 3:0 and zeros above. The mask changes only on such a write.
- R3: Reading address 1 returns the raw conditions. Bit 0 is overrun, bit 1 is timeout, bit 2 is `rx_half` and bit 3 is `tx_half_empty`. The two level bits follow their inputs in the same cycle.
- R4: The overrun flag sets on a clock edge where `rx_frame_done` and `rx_full` are both high. A finished frame with `rx_full` low does not set it.
- R5: The timeout flag sets on the N-th consecutive clock edge at which `rx_empty` is low and `rx_pop` is low, where N = 32 * `cfg_prescale` * (`cfg_rate` + 1). It is still clear after edge N-1.
- R6: An edge with `rx_pop` high or `rx_empty` high restarts the timeout count from zero.
- R7: Writing address 3 acts as a clear register. Bit 0 clears overrun and bit 1 clears timeout. Zero bits have no effect, bits 2 and 3 leave the level conditions untouched, and a read of address 3 returns 0.
- R8: When a set event and a clear write for the same flag share an edge, the flag stays set.
- R9: Reading address 2 returns the raw conditions ANDed bitwise with the mask, using the bit positions of R3.
- R10: `irq_out` is a register holding the OR of the four masked bits, so it is due one edge after the masked status changes.
- R11: The timeout flag fires at most once per idle stretch. Once cleared, it stays clear until a restart (R6) is followed by a further N idle edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 8 | Clock prescale divisor, even, 2 to 254 |
| cfg_rate | input | 8 | Serial clock rate field; bit period = prescale*(rate+1) clocks |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_full | input | 1 | Receive FIFO is full |
| rx_half | input | 1 | Receive FIFO is at least half full |
| tx_half_empty | input | 1 | Transmit FIFO is at least half empty |
| rx_frame_done | input | 1 | Strobe: a received frame has completed |
| rx_pop | input | 1 | Strobe: receive FIFO is being read |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
Reads are combinational, so each status value is sampled on the same falling edge that the address is applied. Sticky flags and the mask are checked on the falling edge after the rising edge that writes them. `irq_out` is checked both before and after the one extra rising edge it needs. For the timeout, the bench counts rising edges from the falling edge where the FIFO becomes non-empty. It samples after edge N-1 and after edge N, with N computed from the prescale and rate values of each sweep point.

// File: rtl/serial_irq_status.sv
module serial_irq_status #(
  parameter int DW      = 32,
  parameter int PRE_W   = 8,
  parameter int RATE_W  = 8,
  parameter int TO_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              rx_half,
  input  logic              tx_half_empty,
  input  logic              rx_frame_done,
  input  logic              rx_pop,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_out
);
  localparam int CNT_W = PRE_W + RATE_W + 1 + $clog2(TO_BITS);
  localparam logic [1:0] A_MASK = 2'd0, A_RAW = 2'd1, A_MSK = 2'd2, A_CLR = 2'd3;

  logic [3:0]       mask_q, raw, masked;
  logic             ovr_q, to_q, irq_q;
  logic [CNT_W-1:0] tcnt, limit;
  logic             wr_mask, wr_clr, restart, to_hit, ovr_set;

  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_clr  = reg_wr && (reg_addr == A_CLR);
  assign ovr_set = rx_frame_done && rx_full;
  assign restart = rx_empty || rx_pop;
  assign limit   = CNT_W'(TO_BITS) * CNT_W'(cfg_prescale) * (CNT_W'(cfg_rate) + CNT_W'(1));
  assign to_hit  = !restart && (tcnt == limit - CNT_W'(1));
  assign raw     = {tx_half_empty, rx_half, to_q, ovr_q};
  assign masked  = raw & mask_q;
  assign irq_out = irq_q;

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = DW'(mask_q);
      A_RAW:   reg_rdata = DW'(raw);
      A_MSK:   reg_rdata = DW'(masked);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovr_q  <= 1'b0;
      to_q   <= 1'b0;
      irq_q  <= 1'b0;
      tcnt   <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[3:0];
      if (ovr_set) ovr_q <= 1'b1;
      else if (wr_clr && reg_wdata[0]) ovr_q <= 1'b0;
      if (to_hit) to_q <= 1'b1;
      else if (wr_clr && reg_wdata[1]) to_q <= 1'b0;
      if (restart) tcnt <= '0;
      else if (tcnt < limit) tcnt <= tcnt + CNT_W'(1);
      irq_q <= |masked;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R2
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_done && rx_full) |=> ovr_q); // R4
  AST_TO_IDLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(!rx_empty && !rx_pop)); // R5
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[0] && !(rx_frame_done && rx_full)) |=> !ovr_q); // R7
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(mask_q != 4'd0)); // R10
endmodule

// File: tb/serial_irq_status_bench.sv
module serial_irq_status_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_prescale = 8'd2, cfg_rate = 8'd0;
  logic rx_empty = 1'b1, rx_full = 1'b0, rx_half = 1'b0, tx_half_empty = 1'b0;
  logic rx_frame_done = 1'b0, rx_pop = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata, v;
  logic irq_out;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  serial_irq_status u_serial_irq_status (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_rate(cfg_rate),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_half(rx_half),
    .tx_half_empty(tx_half_empty), .rx_frame_done(rx_frame_done), .rx_pop(rx_pop),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 mask reset", v, 0);
    rd(2'd2, v); chk("R1 masked reset", v, 0);
    chk("R1 irq reset", {31'd0, irq_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R1 raw after reset", v, 0);

    wr(2'd0, 32'hFFFF_FFFA);
    rd(2'd0, v); chk("R2 mask readback", v, 32'hA);
    wr(2'd1, 32'h5);
    rd(2'd0, v); chk("R2 mask unchanged by other write", v, 32'hA);
    wr(2'd0, 32'h0);

    for (int m = 0; m < 16; m++) begin
      for (int l = 0; l < 4; l++) begin
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'(m);
        rx_half = l[0]; tx_half_empty = l[1];
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd1, v); chk("R3 raw level bits", v, 32'(l << 2));
        rd(2'd2, v); chk("R9 masked status", v, 32'((l << 2) & m));
        chk("R10 irq registered", {31'd0, irq_out}, {31'd0, ((l << 2) & m) != 0});
      end
    end

    wr(2'd0, 32'h4);
    @(negedge clk); rx_half = 1'b0; tx_half_empty = 1'b0;
    @(negedge clk); rx_half = 1'b1;
    rd(2'd2, v); chk("R9 masked same cycle", v, 32'h4);
    chk("R10 irq not yet", {31'd0, irq_out}, 0);
    @(negedge clk);
    chk("R10 irq after one edge", {31'd0, irq_out}, 1);
    rx_half = 1'b0;
    wr(2'd0, 32'h0);

    @(negedge clk); rx_frame_done = 1'b1; rx_full = 1'b0;
    @(negedge clk); rx_frame_done = 1'b0;
    rd(2'd1, v); chk("R4 no overrun when not full", v, 0);
    rx_full = 1'b1; rx_frame_done = 1'b1;
    @(negedge clk); rx_frame_done = 1'b0;
    rd(2'd1, v); chk("R4 overrun sets", v, 1);
    wr(2'd3, 32'h0);
    rd(2'd1, v); chk("R7 zero clear no effect", v, 1);
    rx_half = 1'b1; tx_half_empty = 1'b1;
    wr(2'd3, 32'hC);
    rd(2'd1, v); chk("R7 level bits not clearable", v, 32'hD);
    rd(2'd3, v); chk("R7 clear reads zero", v, 0);
    wr(2'd3, 32'h1);
    rd(2'd1, v); chk("R7 overrun cleared", v, 32'hC);
    rx_half = 1'b0; tx_half_empty = 1'b0;
    @(negedge clk);
    rx_frame_done = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h1;
    @(negedge clk);
    rx_frame_done = 1'b0; reg_wr = 1'b0;
    rd(2'd1, v); chk("R8 set wins over clear", v, 1);
    wr(2'd3, 32'h1);
    rx_full = 1'b0;

    for (int pi = 1; pi <= 3; pi++) begin
      for (int r = 0; r < 3; r++) begin
        int n;
        n = 32 * (2 * pi) * (r + 1);
        @(negedge clk);
        rx_empty = 1'b1; cfg_prescale = 8'(2 * pi); cfg_rate = 8'(r);
        wr(2'd3, 32'h2);
        rx_empty = 1'b0;
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        rd(2'd1, v); chk("R5 timeout clear at N-1", {31'd0, v[1]}, 0);
        @(negedge clk);
        rd(2'd1, v); chk("R5 timeout set at N", {31'd0, v[1]}, 1);
      end
    end

    @(negedge clk);
    rx_empty = 1'b1; cfg_prescale = 8'd2; cfg_rate = 8'd0;
    wr(2'd3, 32'h2);
    rx_empty = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    repeat (63) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v); chk("R6 pop restarts count", {31'd0, v[1]}, 0);
    @(negedge clk);
    rd(2'd1, v); chk("R6 timeout after restart", {31'd0, v[1]}, 1);
    wr(2'd3, 32'h2);
    repeat (100) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v); chk("R11 no refire in same idle stretch", {31'd0, v[1]}, 0);
    rx_empty = 1'b1;
    @(negedge clk); rx_empty = 1'b0;
    repeat (64) @(posedge clk);
    @(negedge clk);
    rd(2'd1, v); chk("R11 refires after restart", {31'd0, v[1]}, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule